// File: doc/BRIEF.md
# Multi-lane DLL enable sequencer

This block brings a memory PHY's delay-locked loops out of reset in a fixed, timed order. There is one master DLL and a set of byte-lane DLLs (four by default). Each DLL gets a phase field, a disable bit and an active-low reset. Every output is registered. Software or a boot controller pulses `start_i` twice. The first run sequences the master DLL and the second run sequences the byte lanes. After that, further runs keep alternating between the two. The phase values for each run are taken from a single packed word. The number of byte lanes that take part depends on whether the data bus is 32 bits wide.

Each run goes through three steps. Hold: disable is high and reset is low. Free: both disable and reset are low. Release: disable is low and reset is released. Each step lasts a programmable number of microseconds, 2, 22 and 22 by default. A prescaler divides the clock by `CLK_PER_US` to make a microsecond tick, and that tick times the steps. `busy_o` is high for the whole run, and `done_o` pulses for one cycle when the run ends.

Top module: `dll_bringup_seq`

## Requirements
- R1: After reset, every DLL has disable = 1, reset_n = 0 and phase = 0, and `busy_o` and `done_o` are 0.
- R2: When a master run is accepted, the master phase output takes bits [21:16] of `phase_word_i`. It holds that value until the next accepted master run, whatever the word does afterwards.
- R3: When a lane run is accepted, each active lane k (k = 0..3) takes the phase nibble `phase_word_i[4k+3:4k]`.
- R4: The lane count is latched when a lane run is accepted. If `wide_bus_i` = 1, lanes 0 to 3 are active. If it is 0, only lanes 0 and 1 are active. Inactive lanes get disable = 1, reset_n = 0 and phase = 0.
- R5: Hold step: the edge that accepts `start_i` sets disable = 1 and reset_n = 0. These values last HOLD_US·CLK_PER_US cycles.
- R6: Free step: disable and reset_n are both 0 for FREE_US·CLK_PER_US cycles. reset_n never rises while disable is high.
- R7: Release step: disable = 0 and reset_n = 1. After RELEASE_US·CLK_PER_US cycles, `done_o` is 1 for exactly one cycle.
- R8: All active lanes change state on the same edge. Lanes 0–1 always show equal values, and so do lanes 2–3.
- R9: Accepted runs alternate between targets, starting with the master after reset.
- R10: A `start_i` pulse while `busy_o` = 1 is ignored. Outputs, timing, latched phases and the next target are unchanged.
- R11: `busy_o` rises on the accepting edge and falls on the edge where `done_o` rises.
- R12: The DLL that is not the target of a run keeps all of its outputs during that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Run request, sampled each clock |
| wide_bus_i | input | 1 | 1 = 32-bit bus (four lanes active) |
| phase_word_i | input | WORD_W | Packed phases: master in [21:16], lane k in [4k+3:4k] |
| mst_phase_o | output | MST_PH_W | Master DLL phase |
| mst_dis_o | output | 1 | Master DLL disable |
| mst_rst_n_o | output | 1 | Master DLL reset, active low |
| lane_phase_o | output | NUM_LANES·LANE_PH_W | Lane phases, lane k in [4k+3:4k] |
| lane_dis_o | output | NUM_LANES | Lane disables |
| lane_rst_n_o | output | NUM_LANES | Lane resets, active low |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
Let edge a be the clock edge that samples `start_i`. Every output is registered, so the hold values appear just after edge a. The free values appear at a + HOLD·C, the release values at a + (HOLD+FREE)·C, and the `done_o` pulse together with the fall of `busy_o` at a + (HOLD+FREE+RELEASE)·C, where C is the cycle count per microsecond. The driver turns these offsets into absolute cycle numbers and queues the expected output vectors. It also queues samples one cycle before each step boundary, so that a step ending early or late is caught. The monitor compares at the falling edge of the exact cycle and reports any queued item whose cycle has passed without a comparison.

// File: rtl/dll_seq_pkg.sv
package dll_seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_HOLD,
      ST_FREE,
      ST_RELEASE
   } seq_state_t;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/dll_us_timer.sv
module dll_us_timer #(
   parameter int CLK_PER_US = 250,
   parameter int US_W       = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run_i,
   input  logic [US_W-1:0] limit_i,
   output logic            expire_o
);

   logic            tick;
   logic [US_W-1:0] us_q;

   generate
      if (CLK_PER_US > 1) begin : g_div
         localparam int DIV_W = $clog2(CLK_PER_US);
         logic [DIV_W-1:0] div_q;

         assign tick = run_i && (div_q == DIV_W'(CLK_PER_US - 1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               div_q <= '0;
            else if (!run_i || tick)
               div_q <= '0;
            else
               div_q <= div_q + 1'b1;
         end
      end else begin : g_nodiv
         assign tick = run_i;
      end
   endgenerate

   assign expire_o = tick && (us_q == limit_i - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         us_q <= '0;
      else if (!run_i || expire_o)
         us_q <= '0;
      else if (tick)
         us_q <= us_q + 1'b1;
   end

endmodule

// File: rtl/dll_step_fsm.sv
module dll_step_fsm
   import dll_seq_pkg::*;
#(
   parameter int US_W       = 5,
   parameter int HOLD_US    = 2,
   parameter int FREE_US    = 22,
   parameter int RELEASE_US = 22
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic            expire_i,
   output logic            run_o,
   output logic [US_W-1:0] limit_o,
   output logic            go_hold_o,
   output logic            go_free_o,
   output logic            go_rel_o,
   output logic            tgt_lane_o,
   output logic            done_o
);

   seq_state_t state_q;
   logic       tgt_q;

   assign run_o      = (state_q != ST_IDLE);
   assign go_hold_o  = start_i && (state_q == ST_IDLE);
   assign go_free_o  = expire_i && (state_q == ST_HOLD);
   assign go_rel_o   = expire_i && (state_q == ST_FREE);
   assign tgt_lane_o = tgt_q;

   always_comb begin
      case (state_q)
         ST_FREE:    limit_o = US_W'(FREE_US);
         ST_RELEASE: limit_o = US_W'(RELEASE_US);
         default:    limit_o = US_W'(HOLD_US);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         tgt_q   <= 1'b0;
         done_o  <= 1'b0;
      end else begin
         done_o <= 1'b0;
         case (state_q)
            ST_IDLE:    if (start_i)  state_q <= ST_HOLD;
            ST_HOLD:    if (expire_i) state_q <= ST_FREE;
            ST_FREE:    if (expire_i) state_q <= ST_RELEASE;
            ST_RELEASE: if (expire_i) begin
               state_q <= ST_IDLE;
               done_o  <= 1'b1;
               tgt_q   <= ~tgt_q;
            end
            default:    state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/dll_lane_unpack.sv
module dll_lane_unpack #(
   parameter int NUM_LANES = 4,
   parameter int LANE_PH_W = 4
) (
   input  logic [NUM_LANES*LANE_PH_W-1:0] word_i,
   input  logic                           wide_i,
   output logic [NUM_LANES*LANE_PH_W-1:0] phase_o,
   output logic [NUM_LANES-1:0]           active_o
);

   localparam int HALF = NUM_LANES / 2;

   generate
      for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
         if (i < HALF) begin : g_always_on
            assign active_o[i] = 1'b1;
         end else begin : g_wide_only
            assign active_o[i] = wide_i;
         end
         assign phase_o[i*LANE_PH_W +: LANE_PH_W] =
            active_o[i] ? word_i[i*LANE_PH_W +: LANE_PH_W] : '0;
      end
   endgenerate

endmodule

// File: rtl/dll_bringup_seq.sv
module dll_bringup_seq
   import dll_seq_pkg::*;
#(
   parameter int CLK_PER_US = 250,
   parameter int NUM_LANES  = 4,
   parameter int WORD_W     = 32,
   parameter int MST_PH_W   = 6,
   parameter int MST_PH_LSB = 16,
   parameter int LANE_PH_W  = 4,
   parameter int HOLD_US    = 2,
   parameter int FREE_US    = 22,
   parameter int RELEASE_US = 22
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           start_i,
   input  logic                           wide_bus_i,
   input  logic [WORD_W-1:0]              phase_word_i,
   output logic [MST_PH_W-1:0]            mst_phase_o,
   output logic                           mst_dis_o,
   output logic                           mst_rst_n_o,
   output logic [NUM_LANES*LANE_PH_W-1:0] lane_phase_o,
   output logic [NUM_LANES-1:0]           lane_dis_o,
   output logic [NUM_LANES-1:0]           lane_rst_n_o,
   output logic                           busy_o,
   output logic                           done_o
);

   localparam int LANE_BITS = NUM_LANES * LANE_PH_W;
   localparam int US_W      = $clog2(max3(HOLD_US, FREE_US, RELEASE_US) + 1);

   generate
      if (CLK_PER_US < 1) begin : g_bad_div
         $error("CLK_PER_US must be at least 1");
      end
      if (NUM_LANES < 2 || (NUM_LANES % 2) != 0) begin : g_bad_lanes
         $error("NUM_LANES must be even and at least 2");
      end
      if (WORD_W < MST_PH_LSB + MST_PH_W || WORD_W < LANE_BITS) begin : g_bad_word
         $error("WORD_W too narrow for the packed phase fields");
      end
      if (HOLD_US < 1 || FREE_US < 1 || RELEASE_US < 1) begin : g_bad_wait
         $error("every step wait must be at least 1 us");
      end
   endgenerate

   logic            expire, run;
   logic [US_W-1:0] limit;
   logic            go_hold, go_free, go_rel, tgt_lane;
   logic            hold_mst, hold_lane;
   logic [LANE_BITS-1:0] unpacked_ph;
   logic [NUM_LANES-1:0] unpacked_act;
   logic [NUM_LANES-1:0] act_q;
   logic            unused_word_bits;

   assign unused_word_bits = ^phase_word_i;

   dll_us_timer #(
      .CLK_PER_US (CLK_PER_US),
      .US_W       (US_W)
   ) timer_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (run),
      .limit_i  (limit),
      .expire_o (expire)
   );

   dll_step_fsm #(
      .US_W       (US_W),
      .HOLD_US    (HOLD_US),
      .FREE_US    (FREE_US),
      .RELEASE_US (RELEASE_US)
   ) fsm_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .expire_i   (expire),
      .run_o      (run),
      .limit_o    (limit),
      .go_hold_o  (go_hold),
      .go_free_o  (go_free),
      .go_rel_o   (go_rel),
      .tgt_lane_o (tgt_lane),
      .done_o     (done_o)
   );

   dll_lane_unpack #(
      .NUM_LANES (NUM_LANES),
      .LANE_PH_W (LANE_PH_W)
   ) unpack_i (
      .word_i   (phase_word_i[LANE_BITS-1:0]),
      .wide_i   (wide_bus_i),
      .phase_o  (unpacked_ph),
      .active_o (unpacked_act)
   );

   assign busy_o    = run;
   assign hold_mst  = go_hold && !tgt_lane;
   assign hold_lane = go_hold && tgt_lane;

   // master DLL control
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mst_phase_o <= '0;
         mst_dis_o   <= 1'b1;
         mst_rst_n_o <= 1'b0;
      end else if (hold_mst) begin
         mst_phase_o <= phase_word_i[MST_PH_LSB +: MST_PH_W];
         mst_dis_o   <= 1'b1;
         mst_rst_n_o <= 1'b0;
      end else if (go_free && !tgt_lane) begin
         mst_dis_o   <= 1'b0;
      end else if (go_rel && !tgt_lane) begin
         mst_rst_n_o <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         act_q <= '0;
      else if (hold_lane)
         act_q <= unpacked_act;
   end

   // byte-lane DLL control, one register set per lane
   generate
      for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane_ctl
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lane_phase_o[i*LANE_PH_W +: LANE_PH_W] <= '0;
               lane_dis_o[i]   <= 1'b1;
               lane_rst_n_o[i] <= 1'b0;
            end else if (hold_lane) begin
               lane_phase_o[i*LANE_PH_W +: LANE_PH_W] <= unpacked_ph[i*LANE_PH_W +: LANE_PH_W];
               lane_dis_o[i]   <= 1'b1;
               lane_rst_n_o[i] <= 1'b0;
            end else if (go_free && tgt_lane && act_q[i]) begin
               lane_dis_o[i]   <= 1'b0;
            end else if (go_rel && tgt_lane && act_q[i]) begin
               lane_rst_n_o[i] <= 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/dll_bringup_seq_chk.sv
module dll_bringup_seq_chk #(
   parameter int NUM_LANES = 4,
   parameter int MST_PH_W  = 6
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 busy_o,
   input logic                 done_o,
   input logic [MST_PH_W-1:0]  mst_phase_o,
   input logic                 mst_dis_o,
   input logic                 mst_rst_n_o,
   input logic [NUM_LANES-1:0] lane_dis_o,
   input logic [NUM_LANES-1:0] lane_rst_n_o
);

   localparam int HALF = NUM_LANES / 2;

   logic lo_rst_ones, lo_rst_zero, hi_rst_ones, hi_rst_zero;
   logic lo_dis_ones, lo_dis_zero, hi_dis_ones, hi_dis_zero;

   assign lo_rst_ones = (lane_rst_n_o[HALF-1:0] == {HALF{1'b1}});
   assign lo_rst_zero = (lane_rst_n_o[HALF-1:0] == '0);
   assign hi_rst_ones = (lane_rst_n_o[NUM_LANES-1:HALF] == {HALF{1'b1}});
   assign hi_rst_zero = (lane_rst_n_o[NUM_LANES-1:HALF] == '0);
   assign lo_dis_ones = (lane_dis_o[HALF-1:0] == {HALF{1'b1}});
   assign lo_dis_zero = (lane_dis_o[HALF-1:0] == '0);
   assign hi_dis_ones = (lane_dis_o[NUM_LANES-1:HALF] == {HALF{1'b1}});
   assign hi_dis_zero = (lane_dis_o[NUM_LANES-1:HALF] == '0);

   // R7: completion pulse lasts one cycle
   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R11: busy only drops together with done
   a_r11_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);

   // R10: master phase cannot move while a run is in progress
   a_r10_phase_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> $stable(mst_phase_o));

   // R6: reset is released only after disable has been low
   a_r6_release_after_free: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mst_rst_n_o) |-> (!mst_dis_o && $past(!mst_dis_o)));

   // R5: disable rises only while the DLL is held in reset
   a_r5_hold_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mst_dis_o) |-> !mst_rst_n_o);

   // R8: lanes in each half always move as a group
   a_r8_lanes_grouped: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_rst_ones || lo_rst_zero) && (hi_rst_ones || hi_rst_zero) &&
      (lo_dis_ones || lo_dis_zero) && (hi_dis_ones || hi_dis_zero));

   // R4: upper lanes never leave reset unless the lower lanes have too
   a_r4_upper_needs_lower: assert property (@(posedge clk) disable iff (!rst_n)
      (!hi_rst_zero) |-> lo_rst_ones);

endmodule

bind dll_bringup_seq dll_bringup_seq_chk #(
   .NUM_LANES (NUM_LANES),
   .MST_PH_W  (MST_PH_W)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .busy_o       (busy_o),
   .done_o       (done_o),
   .mst_phase_o  (mst_phase_o),
   .mst_dis_o    (mst_dis_o),
   .mst_rst_n_o  (mst_rst_n_o),
   .lane_dis_o   (lane_dis_o),
   .lane_rst_n_o (lane_rst_n_o)
);

// File: tb/dll_bringup_seq_tb_top.sv
`timescale 1ns/1ps
module dll_bringup_seq_tb_top;

   localparam int C     = 250;
   localparam int HOLD  = 2;
   localparam int FREE  = 22;
   localparam int REL   = 22;

   typedef struct packed {
      logic [5:0]  m_ph;
      logic        m_dis;
      logic        m_rst;
      logic [15:0] l_ph;
      logic [3:0]  l_dis;
      logic [3:0]  l_rst;
      logic        busy;
      logic        done;
   } snap_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        wide_bus_i = 1'b0;
   logic [31:0] phase_word_i = '0;
   logic [5:0]  mst_phase_o;
   logic        mst_dis_o, mst_rst_n_o;
   logic [15:0] lane_phase_o;
   logic [3:0]  lane_dis_o, lane_rst_n_o;
   logic        busy_o, done_o;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   // expectation model
   logic [5:0]  m_ph = '0;
   logic        m_dis = 1'b1, m_rst = 1'b0;
   logic [15:0] l_ph = '0;
   logic [3:0]  l_dis = 4'hF, l_rst = 4'h0;
   bit          tgt_lane = 1'b0;

   int    cq[$];
   string tq[$];
   snap_t eq[$];

   always #2 clk = ~clk;

   always @(posedge clk) cyc = cyc + 1;

   dll_bringup_seq #(
      .CLK_PER_US (C),
      .HOLD_US    (HOLD),
      .FREE_US    (FREE),
      .RELEASE_US (REL)
   ) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .wide_bus_i   (wide_bus_i),
      .phase_word_i (phase_word_i),
      .mst_phase_o  (mst_phase_o),
      .mst_dis_o    (mst_dis_o),
      .mst_rst_n_o  (mst_rst_n_o),
      .lane_phase_o (lane_phase_o),
      .lane_dis_o   (lane_dis_o),
      .lane_rst_n_o (lane_rst_n_o),
      .busy_o       (busy_o),
      .done_o       (done_o)
   );

   function automatic snap_t actual();
      return {mst_phase_o, mst_dis_o, mst_rst_n_o, lane_phase_o,
              lane_dis_o, lane_rst_n_o, busy_o, done_o};
   endfunction

   task automatic push(input int at, input string tag, input bit b, input bit d);
      snap_t s;
      s = {m_ph, m_dis, m_rst, l_ph, l_dis, l_rst, b, d};
      cq.push_back(at);
      tq.push_back(tag);
      eq.push_back(s);
   endtask

   task automatic compare(input string tag, input snap_t exp_v);
      snap_t act_v;
      act_v = actual();
      total++;
      if (act_v !== exp_v) begin
         bad++;
         $display("FAIL %s cyc=%0d act=%h exp=%h", tag, cyc, act_v, exp_v);
      end
   endtask

   // monitor: pops queued expectations in their due cycle
   always @(negedge clk) begin
      if (cq.size() > 0) begin
         if (cq[0] == cyc) begin
            compare(tq[0], eq[0]);
            void'(cq.pop_front());
            void'(tq.pop_front());
            void'(eq.pop_front());
         end else if (cq[0] < cyc) begin
            total++;
            bad++;
            $display("FAIL %s missed sample act=cyc%0d exp=cyc%0d", tq[0], cyc, cq[0]);
            void'(cq.pop_front());
            void'(tq.pop_front());
            void'(eq.pop_front());
         end
      end
   end

   // driver: one run, expectations queued before start is applied
   task automatic run_seq(input logic [31:0] w, input bit wide, input bit poke);
      int  c;
      bit  act [4];
      @(negedge clk);
      c = cyc;
      for (int k = 0; k < 4; k++) act[k] = (k < 2) || wide;
      // hold step
      if (!tgt_lane) begin
         m_ph = w[21:16]; m_dis = 1'b1; m_rst = 1'b0;
      end else begin
         for (int k = 0; k < 4; k++) begin
            l_ph[4*k +: 4] = act[k] ? w[4*k +: 4] : 4'h0;
            l_dis[k] = 1'b1;
            l_rst[k] = 1'b0;
         end
      end
      push(c + 1, tgt_lane ? "R3 R4 R5 R9 R11" : "R2 R5 R9 R11", 1'b1, 1'b0);
      push(c + HOLD*C, "R5", 1'b1, 1'b0);
      // free step
      if (!tgt_lane) m_dis = 1'b0;
      else for (int k = 0; k < 4; k++) if (act[k]) l_dis[k] = 1'b0;
      push(c + 1 + HOLD*C, "R6 R8", 1'b1, 1'b0);
      if (poke) push(c + 12 + HOLD*C, "R10", 1'b1, 1'b0);
      push(c + (HOLD+FREE)*C, "R6", 1'b1, 1'b0);
      // release step
      if (!tgt_lane) m_rst = 1'b1;
      else for (int k = 0; k < 4; k++) if (act[k]) l_rst[k] = 1'b1;
      push(c + 1 + (HOLD+FREE)*C, "R7 R8 R12", 1'b1, 1'b0);
      push(c + (HOLD+FREE+REL)*C, "R7 R11", 1'b1, 1'b0);
      push(c + 1 + (HOLD+FREE+REL)*C, "R7 R11 R12", 1'b0, 1'b1);
      push(c + 2 + (HOLD+FREE+REL)*C, "R7", 1'b0, 1'b0);
      tgt_lane = !tgt_lane;

      start_i = 1'b1;
      phase_word_i = w;
      wide_bus_i = wide;
      @(negedge clk);
      start_i = 1'b0;
      phase_word_i = 32'hFFFF_FFFF;   // R2: later word changes must not matter
      wide_bus_i = !wide;
      if (poke) begin
         while (cyc < c + 10 + HOLD*C) @(negedge clk);
         start_i = 1'b1;               // R10: request while busy
         phase_word_i = 32'h0015_1111;
         @(negedge clk);
         start_i = 1'b0;
      end
      while (cyc < c + 3 + (HOLD+FREE+REL)*C) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL R7 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      compare("R1", {6'h0, 1'b1, 1'b0, 16'h0, 4'hF, 4'h0, 1'b0, 1'b0});
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      compare("R1", {6'h0, 1'b1, 1'b0, 16'h0, 4'hF, 4'h0, 1'b0, 1'b0});

      run_seq(32'h0035_9ABC, 1'b0, 1'b1); // master, with ignored start
      run_seq(32'h1234_A5C3, 1'b1, 1'b0); // four lanes
      run_seq(32'h003F_FFFF, 1'b1, 1'b0); // master again, max phase
      run_seq(32'h0000_7E9D, 1'b0, 1'b0); // two lanes, upper back to reset

      repeat (4) @(negedge clk);
      total++;
      if (cq.size() != 0) begin
         bad++;
         $display("FAIL R7 pending act=%0d exp=0", cq.size());
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule